// File: doc/BRIEF.md
# Function Configuration Header

This block holds the 256-byte configuration space of a single device function. Software reaches it through a port that addresses whole dwords, with four byte enables on writes. The first 64 bytes carry a standard header. That header contains fixed identity values, a command register whose enable bits gate address decoding, an interrupt routing byte pair, and six base address registers. Each base address register drives its own address decoder. Every offset past the header reads as zero.

Each base address register is sized by a parameter as a power of two. Only the bits above that size can be written, so software can learn a region's size by writing all ones and reading the value back. A region is either a memory region or an I/O region. The memory decoders compare a presented bus address against their base only while memory decoding is enabled. The I/O decoders do the same only while I/O decoding is enabled. After reset both enables are clear, so the function answers nothing except configuration accesses.

Top module: `cfg_space_hdr`

## Requirements
- R1: After reset, the command dword reads 0, every base register reads only its type flag, the interrupt-line byte reads 0, cfg_rdata is 0, all hit outputs are low, and io_en, mem_en and master_en are low.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor value in bytes 0-1 (little-endian). Writes to it are ignored.
- R3: Dword 2 reads {CLASS_CODE, REV_ID}. The base class group is in byte 3 and the revision is in byte 0. The dword is read-only.
- R4: Dword 1 holds the command enables: bit 0 enables I/O decoding, bit 1 enables memory decoding and bit 2 enables bus mastering. All three read back. All other bits of the dword read zero, and the three enables appear on io_en, mem_en and master_en.
- R5: An implemented base register (dwords 4-9) of size 2^N keeps only address bits 31..N. A memory region reads its low four bits as 0000. An I/O region reads bit 0 as 1 and bit 1 as 0. Writing all ones therefore reads back ~(2^N-1) with the type flag added.
- R6: A base register whose size parameter is 0 reads zero and ignores writes. Its hit output stays low.
- R7: hit_vec[i] is high only while the region's enable is set, dec_is_io matches the region's type (1 = I/O), and dec_addr[31:N] equals the programmed base.
- R8: Byte 0 of dword 15 (offset 60) is a read/write interrupt-line byte. Byte 1 (offset 61) is read-only and reads IRQ_PIN, where 0 means no interrupt and 1-4 name the pin used. Bytes 2-3 read zero.
- R9: Dword 3, dwords 10-14 and all dwords 16-63 read zero, and writes to them change no readable state.
- R10: A read (cfg_sel=1, cfg_we=0) at a clock edge sets cfg_rdata at that edge. cfg_rdata holds its value through writes and idle cycles.
- R11: A write changes only the bytes whose cfg_be bit is 1. Byte 0 of the dword is cfg_be[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Configuration access strobe for this function |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw_addr | input | 6 | Dword index within the 256-byte space |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| dec_addr | input | 32 | Bus address presented for decoding |
| dec_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| hit_vec | output | 6 | Per-region address match |
| io_en | output | 1 | I/O decode enable |
| mem_en | output | 1 | Memory decode enable |
| master_en | output | 1 | Bus master enable |

## Verification
The bench probes the size of each region by writing all ones and reading the value back. A register that let its low bits be written, or that lost its type flag, would return the wrong mask. It checks decoding at both edges of each window, with each enable off and then on, and with the cycle type reversed. A decoder that ignored the enable, the type or the low bound would raise a false hit. It also writes to read-only identity fields, to the interrupt-pin byte and to reserved offsets, and tries partial byte enables. A design that latched any of those bytes would show changed read data.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BARS  = 6;
  localparam int DW_AW     = 6;
  localparam int DW_ID     = 0;
  localparam int DW_CMD    = 1;
  localparam int DW_CLASS  = 2;
  localparam int DW_BAR0   = 4;
  localparam int DW_IRQ    = 15;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_bar.sv
module cfg_bar #(
  parameter int   SIZE_LOG2 = 12,
  parameter logic IS_IO     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        io_en,
  input  logic        mem_en,
  input  logic [31:0] dec_addr,
  input  logic        dec_is_io,
  output logic [31:0] rd_val,
  output logic        hit
);
  import cfg_hdr_pkg::*;

  generate
    if (SIZE_LOG2 == 0) begin : g_absent
      logic unused_bar_in;
      assign unused_bar_in = ^{clk, rst_n, wr_en, be, wdata, io_en, mem_en, dec_addr, dec_is_io};
      assign rd_val = '0;
      assign hit    = 1'b0;
    end else begin : g_present
      localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
      localparam logic [31:0] TYPE_FLAG = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

      logic [31:0] base_q, base_d;
      logic        space_ok;

      always_comb begin
        base_d = base_q;
        if (wr_en) base_d = be_merge(base_q, wdata, be) & ADDR_MASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
      end

      assign space_ok = IS_IO ? (io_en && dec_is_io) : (mem_en && !dec_is_io);
      assign hit      = space_ok && ((dec_addr & ADDR_MASK) == base_q);
      assign rd_val   = base_q | TYPE_FLAG;

      p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q & ~ADDR_MASK) == 32'd0);
      p_hit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (IS_IO ? (io_en && dec_is_io) : (mem_en && !dec_is_io)));
    end
  endgenerate
endmodule

// File: rtl/cfg_ctl.sv
module cfg_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic       wr_line,
  input  logic [7:0] wbyte,
  output logic       io_en,
  output logic       mem_en,
  output logic       master_en,
  output logic [7:0] irq_line
);
  logic [2:0] cmd_q, cmd_d;
  logic [7:0] line_q, line_d;

  always_comb begin
    cmd_d  = cmd_q;
    line_d = line_q;
    if (wr_cmd)  cmd_d  = wbyte[2:0];
    if (wr_line) line_d = wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      line_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      line_q <= line_d;
    end
  end

  assign io_en     = cmd_q[0];
  assign mem_en    = cmd_q[1];
  assign master_en = cmd_q[2];
  assign irq_line  = line_q;

  p_cmd_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q));
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
  parameter logic [15:0] VENDOR_ID  = 16'hA55A,
  parameter logic [15:0] DEVICE_ID  = 16'h0C31,
  parameter logic [23:0] CLASS_CODE = 24'h040000,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [7:0]  IRQ_PIN    = 8'h01
) (
  input  logic [cfg_hdr_pkg::DW_AW-1:0]                  dw_addr,
  input  logic                                           io_en,
  input  logic                                           mem_en,
  input  logic                                           master_en,
  input  logic [7:0]                                     irq_line,
  input  logic [cfg_hdr_pkg::NUM_BARS-1:0][31:0]         bar_rd,
  output logic [31:0]                                    rd_data
);
  import cfg_hdr_pkg::*;

  always_comb begin
    rd_data = '0;
    if (dw_addr >= DW_AW'(DW_BAR0) && dw_addr < DW_AW'(DW_BAR0 + NUM_BARS)) begin
      rd_data = bar_rd[dw_addr - DW_AW'(DW_BAR0)];
    end else begin
      case (dw_addr)
        DW_AW'(DW_ID):    rd_data = {DEVICE_ID, VENDOR_ID};
        DW_AW'(DW_CMD):   rd_data = {29'd0, master_en, mem_en, io_en};
        DW_AW'(DW_CLASS): rd_data = {CLASS_CODE, REV_ID};
        DW_AW'(DW_IRQ):   rd_data = {16'd0, IRQ_PIN, irq_line};
        default:          rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_space_hdr.sv
module cfg_space_hdr #(
  parameter logic [15:0] VENDOR_ID  = 16'hA55A,
  parameter logic [15:0] DEVICE_ID  = 16'h0C31,
  parameter logic [23:0] CLASS_CODE = 24'h040000,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [7:0]  IRQ_PIN    = 8'h01,
  parameter int          BAR_LOG2 [cfg_hdr_pkg::NUM_BARS] = '{12, 5, 4, 0, 0, 0},
  parameter logic [cfg_hdr_pkg::NUM_BARS-1:0] BAR_IO = 6'b000010
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_sel,
  input  logic                            cfg_we,
  input  logic [cfg_hdr_pkg::DW_AW-1:0]   cfg_dw_addr,
  input  logic [3:0]                      cfg_be,
  input  logic [31:0]                     cfg_wdata,
  output logic [31:0]                     cfg_rdata,
  input  logic [31:0]                     dec_addr,
  input  logic                            dec_is_io,
  output logic [cfg_hdr_pkg::NUM_BARS-1:0] hit_vec,
  output logic                            io_en,
  output logic                            mem_en,
  output logic                            master_en
);
  import cfg_hdr_pkg::*;

  logic                          wr_acc, rd_acc;
  logic                          wr_cmd, wr_line;
  logic [NUM_BARS-1:0]           bar_wr;
  logic [NUM_BARS-1:0][31:0]     bar_rd;
  logic [7:0]                    irq_line;
  logic [31:0]                   mux_data;
  logic [31:0]                   rdata_q, rdata_d;

  assign wr_acc  = cfg_sel && cfg_we;
  assign rd_acc  = cfg_sel && !cfg_we;
  assign wr_cmd  = wr_acc && cfg_be[0] && (cfg_dw_addr == DW_AW'(DW_CMD));
  assign wr_line = wr_acc && cfg_be[0] && (cfg_dw_addr == DW_AW'(DW_IRQ));

  cfg_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .wr_line   (wr_line),
    .wbyte     (cfg_wdata[7:0]),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .master_en (master_en),
    .irq_line  (irq_line)
  );

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
      assign bar_wr[g] = wr_acc && (cfg_dw_addr == DW_AW'(DW_BAR0 + g));
      cfg_bar #(.SIZE_LOG2(BAR_LOG2[g]), .IS_IO(BAR_IO[g])) u_bar (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bar_wr[g]),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .dec_addr  (dec_addr),
        .dec_is_io (dec_is_io),
        .rd_val    (bar_rd[g]),
        .hit       (hit_vec[g])
      );
    end
  endgenerate

  cfg_rd_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .REV_ID(REV_ID), .IRQ_PIN(IRQ_PIN)
  ) u_mux (
    .dw_addr   (cfg_dw_addr),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .master_en (master_en),
    .irq_line  (irq_line),
    .bar_rd    (bar_rd),
    .rd_data   (mux_data)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_acc) rdata_d = mux_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign cfg_rdata = rdata_q;

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_sel && !cfg_we) |=> $stable(cfg_rdata));
  p_no_hit_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !mem_en) |-> (hit_vec == '0));
  p_enables_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_sel && cfg_we) |=> ($stable(io_en) && $stable(mem_en) && $stable(master_en)));
  p_io_cycle_no_mem_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_is_io |-> ((hit_vec & ~BAR_IO) == '0));
endmodule

// File: tb/cfg_space_hdr_bench.sv
module cfg_space_hdr_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n;
  logic        cfg_sel, cfg_we;
  logic [5:0]  cfg_dw_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [31:0] dec_addr;
  logic        dec_is_io;
  logic [5:0]  hit_vec;
  logic        io_en, mem_en, master_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  cfg_space_hdr u_cfg_space_hdr (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dec_addr(dec_addr), .dec_is_io(dec_is_io),
    .hit_vec(hit_vec), .io_en(io_en), .mem_en(mem_en), .master_en(master_en)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 1; cfg_dw_addr = 6'(a); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 0; cfg_we = 0; cfg_be = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 0; cfg_dw_addr = 6'(a);
    @(negedge clk);
    cfg_sel = 0;
    d = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 hits", {26'd0, hit_vec}, 0);
    chk("R1 enables", {29'd0, master_en, mem_en, io_en}, 0);
    rd(1, d);  chk("R1 cmd", d, 0);
    rd(4, d);  chk("R1 bar0", d, 32'h0);
    rd(5, d);  chk("R1 bar1 io flag", d, 32'h1);
    rd(15, d); chk("R1 irq dword", d, 32'h0000_0100);
  endtask

  task automatic t_identity;
    logic [31:0] d;
    rd(0, d); chk("R2 id dword", d, 32'h0C31_A55A);
    wr(0, 4'hF, 32'h1234_5678);
    rd(0, d); chk("R2 id after write", d, 32'h0C31_A55A);
    rd(2, d); chk("R3 class/rev", d, 32'h0400_0002);
    chk("R3 base class byte", {24'd0, d[31:24]}, 32'h04);
    wr(2, 4'hF, 32'hFFFF_FFFF);
    rd(2, d); chk("R3 class after write", d, 32'h0400_0002);
  endtask

  task automatic t_command;
    logic [31:0] d;
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd(1, d); chk("R4 cmd all ones", d, 32'h7);
    chk("R4 enable pins", {29'd0, master_en, mem_en, io_en}, 32'h7);
    wr(1, 4'hF, 32'h0000_0004);
    rd(1, d); chk("R4 master only", d, 32'h4);
    wr(1, 4'hE, 32'h0000_0003);
    rd(1, d); chk("R11 cmd be0 off", d, 32'h4);
    wr(1, 4'hF, 32'h0);
  endtask

  task automatic t_sizing;
    logic [31:0] d;
    for (int i = 4; i < 10; i++) wr(i, 4'hF, 32'hFFFF_FFFF);
    rd(4, d); chk("R5 bar0 mem 4K mask", d, 32'hFFFF_F000);
    rd(5, d); chk("R5 bar1 io 32B mask", d, 32'hFFFF_FFE1);
    rd(6, d); chk("R5 bar2 mem 16B mask", d, 32'hFFFF_FFF0);
    rd(7, d); chk("R6 bar3 absent", d, 0);
    rd(9, d); chk("R6 bar5 absent", d, 0);
    wr(4, 4'h0, 32'h0);
    rd(4, d); chk("R11 bar no be", d, 32'hFFFF_F000);
    wr(4, 4'h8, 32'h12AB_CDEF);
    rd(4, d); chk("R11 bar be3 only", d, 32'h12FF_F000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(4, 4'hF, 32'hF100_0000);
    wr(5, 4'hF, 32'h0000_E020);
    rd(5, d); chk("R5 io base readback", d, 32'h0000_E021);
    for (int i = 7; i < 10; i++) wr(i, 4'hF, 32'h0);
    wr(6, 4'hF, 32'h0);
    dec_is_io = 0; dec_addr = 32'hF100_0123;
    #1 chk("R7 mem disabled", {26'd0, hit_vec}, 0);
    wr(1, 4'hF, 32'h2);
    dec_addr = 32'hF100_0000; #1 chk("R7 mem low edge", {26'd0, hit_vec}, 32'h1);
    dec_addr = 32'hF100_0FFF; #1 chk("R7 mem high edge", {26'd0, hit_vec}, 32'h1);
    dec_addr = 32'hF100_1000; #1 chk("R7 mem past end", {26'd0, hit_vec}, 0);
    dec_addr = 32'hF100_0010; dec_is_io = 1;
    #1 chk("R7 io cycle on mem window", {26'd0, hit_vec}, 0);
    dec_addr = 32'h0000_E03F; #1 chk("R7 io disabled", {26'd0, hit_vec}, 0);
    wr(1, 4'hF, 32'h1);
    dec_addr = 32'h0000_E020; #1 chk("R7 io low edge", {26'd0, hit_vec}, 32'h2);
    dec_addr = 32'h0000_E03F; #1 chk("R7 io high edge", {26'd0, hit_vec}, 32'h2);
    dec_addr = 32'h0000_E040; #1 chk("R7 io past end", {26'd0, hit_vec}, 0);
    dec_addr = 32'h0000_0000; dec_is_io = 0;
    #1 chk("R6 absent never hits at 0", {26'd0, hit_vec}, 0);
    wr(1, 4'hF, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(15, 4'hF, 32'hFFFF_FF0A);
    rd(15, d); chk("R8 line rw pin ro", d, 32'h0000_010A);
    wr(15, 4'hE, 32'h0000_0055);
    rd(15, d); chk("R11 line be0 off", d, 32'h0000_010A);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(3, 4'hF, 32'hDEAD_BEEF);  rd(3, d);  chk("R9 dword3", d, 0);
    wr(12, 4'hF, 32'hDEAD_BEEF); rd(12, d); chk("R9 dword12", d, 0);
    wr(16, 4'hF, 32'h0000_0007); rd(16, d); chk("R9 dword16", d, 0);
    wr(63, 4'hF, 32'hFFFF_FFFF); rd(63, d); chk("R9 dword63", d, 0);
    rd(1, d); chk("R9 cmd untouched", d, 0);
    rd(15, d); chk("R9 irq untouched", d, 32'h0000_010A);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rd(0, d);
    wr(1, 4'hF, 32'h0);
    chk("R10 hold over write", cfg_rdata, 32'h0C31_A55A);
    @(negedge clk); @(negedge clk);
    chk("R10 hold idle", cfg_rdata, 32'h0C31_A55A);
  endtask

  initial begin
    cfg_sel = 0; cfg_we = 0; cfg_dw_addr = 0; cfg_be = 0; cfg_wdata = 0;
    dec_addr = 0; dec_is_io = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_identity;
    t_command;
    t_sizing;
    t_decode;
    t_irq;
    t_reserved;
    t_hold;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule